// File: doc/BRIEF.md
# Sequential Line Prefetcher

This unit sits next to a cache and watches the stream of demand accesses the cache reports. For each access it may ask the cache to fetch the line that directly follows the one just touched. It issues at most one request per access, always for the next line. A two-bit mode input selects when a request is wanted. The first mode fires on every access. The second fires only on misses, which costs some hit ratio but saves memory traffic. The third is a tagged scheme: it fires on a miss, and also on the first demand hit to a line that an earlier prefetch brought in.

The cache keeps a prefetched bit for each line and passes its value in with every access. When a demand hit finds that bit set, the unit pulses `clear_tag` so the cache clears the bit, and the line cannot re-arm the tagged mode. Before a candidate address is queued, the unit drops it in three cases: it lies past the top of the address space, a same-cycle probe shows the cache already holds it, or it is already waiting in the request queue. Accepted requests wait in a small FIFO and leave through a valid/ready handshake. When the FIFO is full, a new request is discarded so that the processor never stalls. Saturating counters track issued, discarded and useful prefetches.

Top module: `seq_prefetch`

## Requirements
- R1: With `mode` = 0, every valid access, hit or miss, produces a prefetch candidate.
- R2: With `mode` = 1, only a valid access with `acc_hit` = 0 produces a candidate.
- R3: With `mode` = 2, a candidate comes from a miss, or from a hit with `acc_pf_tag` = 1. A hit with `acc_pf_tag` = 0 produces none.
- R4: The candidate line is `acc_line` + 1, and it is driven on `probe_line` in the same cycle. When `acc_line` is all ones, the candidate is suppressed and the address does not wrap to zero. A suppressed candidate is not counted as dropped.
- R5: A candidate is discarded without being counted when `probe_hit` is 1 in the access cycle.
- R6: A candidate equal to a line already held in the queue is discarded without being counted. The queue never holds two equal lines.
- R7: The queue holds at most QD (default 2) lines. A candidate that passes R4 to R6 while the queue is full, judged at the start of the cycle, is discarded and increments `cnt_dropped`. Otherwise it is appended and is visible on `req_valid`/`req_line` from the next cycle.
- R8: Requests leave in FIFO order. `req_valid` is high while the queue is non-empty, and `req_line` stays stable until `req_ready` is seen.
- R9: `clear_tag` is high, combinationally, exactly when a valid access has `acc_hit` = 1 and `acc_pf_tag` = 1 in any mode. Each such access increments `cnt_useful`.
- R10: `cnt_issued` increments on each cycle with `req_valid` and `req_ready` both high. All three counters saturate at their all-ones value.
- R11: After reset the queue is empty and all counters are zero. `mode` = 3 produces no candidates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 0 every access, 1 miss only, 2 tagged, 3 off |
| acc_valid | input | 1 | Demand access event this cycle |
| acc_line | input | AW | Line address of the access |
| acc_hit | input | 1 | Access hit in the cache |
| acc_pf_tag | input | 1 | Prefetched bit of the hit line |
| probe_line | output | AW | Next-line address offered for a presence lookup |
| probe_hit | input | 1 | Cache already holds `probe_line` |
| clear_tag | output | 1 | Tells the cache to clear the accessed line's prefetched bit |
| req_valid | output | 1 | Fill request pending |
| req_line | output | AW | Line address of the fill request |
| req_ready | input | 1 | Cache accepts the request |
| cnt_issued | output | CW | Requests handed to the cache |
| cnt_dropped | output | CW | Candidates lost to a full queue |
| cnt_useful | output | CW | Demand hits on prefetched lines |

## Verification
Some properties are checked by assertions on every cycle. The queue never exceeds its depth. A request that is not accepted holds its line. No request ever targets line zero, which only a wrap could produce. The queue never holds duplicates. The issued and dropped counters move only after a handshake or while the queue is full. What the assertions cannot show is whether the right accesses trigger requests under each mode, and whether presence, pending and top-of-space filters are applied in the right combination. The bench's reference model shows these through directed mode sequences and random traffic near the top of a reduced address space. The same model exercises counter saturation.

// File: rtl/seq_prefetch.sv
module seq_prefetch #(
  parameter int AW = 26,
  parameter int CW = 16,
  parameter int QD = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic          acc_valid,
  input  logic [AW-1:0] acc_line,
  input  logic          acc_hit,
  input  logic          acc_pf_tag,
  output logic [AW-1:0] probe_line,
  input  logic          probe_hit,
  output logic          clear_tag,
  output logic          req_valid,
  output logic [AW-1:0] req_line,
  input  logic          req_ready,
  output logic [CW-1:0] cnt_issued,
  output logic [CW-1:0] cnt_dropped,
  output logic [CW-1:0] cnt_useful
);
  localparam int QW = $clog2(QD + 1);
  localparam logic [1:0] M_ALL = 2'd0, M_MISS = 2'd1, M_TAG = 2'd2;

  logic [AW-1:0] q [QD];
  logic [QW-1:0] count;
  logic          trig, at_top, pending, cand, full, push, drop, pop;
  logic [QW-1:0] wr_idx;

  assign probe_line = acc_line + AW'(1);
  assign at_top     = &acc_line;
  assign clear_tag  = acc_valid && acc_hit && acc_pf_tag;

  assign trig = acc_valid && ((mode == M_ALL) ||
                              (mode == M_MISS && !acc_hit) ||
                              (mode == M_TAG && (!acc_hit || acc_pf_tag)));

  always_comb begin
    pending = 1'b0;
    for (int i = 0; i < QD; i++)
      if (QW'(i) < count && q[i] == probe_line) pending = 1'b1;
  end

  assign cand   = trig && !at_top && !probe_hit && !pending;
  assign full   = (count == QW'(QD));
  assign push   = cand && !full;
  assign drop   = cand && full;
  assign pop    = (count != '0) && req_ready;
  assign wr_idx = count - QW'(pop);

  assign req_valid = (count != '0);
  assign req_line  = q[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      for (int i = 0; i < QD; i++) q[i] <= '0;
    end else begin
      if (pop)
        for (int i = 0; i < QD - 1; i++) q[i] <= q[i+1];
      if (push)
        for (int i = 0; i < QD; i++)
          if (QW'(i) == wr_idx) q[i] <= probe_line;
      count <= count + QW'(push) - QW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_issued  <= '0;
      cnt_dropped <= '0;
      cnt_useful  <= '0;
    end else begin
      if (pop && !(&cnt_issued))        cnt_issued  <= cnt_issued + CW'(1);
      if (drop && !(&cnt_dropped))      cnt_dropped <= cnt_dropped + CW'(1);
      if (clear_tag && !(&cnt_useful))  cnt_useful  <= cnt_useful + CW'(1);
    end
  end

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    count <= QW'(QD));

  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_line)));

  p_no_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_line != '0));

  p_drop_when_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt_dropped) |-> $past(count) == QW'(QD));

  p_issue_on_handshake_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt_issued) |-> $past(req_valid && req_ready));

  generate
    if (QD >= 2) begin : g_distinct
      p_distinct_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (count >= QW'(2)) |-> (q[0] != q[1]));
    end
  endgenerate
endmodule

// File: tb/test_seq_prefetch.sv
`timescale 1ns/1ps
module test_seq_prefetch;
  localparam int AW = 6;
  localparam int CW = 4;
  localparam int QD = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    mode;
  logic          acc_valid, acc_hit, acc_pf_tag, probe_hit, req_ready;
  logic [AW-1:0] acc_line;
  logic [AW-1:0] probe_line, req_line;
  logic          clear_tag, req_valid;
  logic [CW-1:0] cnt_issued, cnt_dropped, cnt_useful;

  always #4 clk = ~clk;

  seq_prefetch #(.AW(AW), .CW(CW), .QD(QD)) i_seq_prefetch (
    .clk(clk), .rst_n(rst_n), .mode(mode), .acc_valid(acc_valid),
    .acc_line(acc_line), .acc_hit(acc_hit), .acc_pf_tag(acc_pf_tag),
    .probe_line(probe_line), .probe_hit(probe_hit), .clear_tag(clear_tag),
    .req_valid(req_valid), .req_line(req_line), .req_ready(req_ready),
    .cnt_issued(cnt_issued), .cnt_dropped(cnt_dropped), .cnt_useful(cnt_useful));

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [AW-1:0] mq [QD];
  int            mcount;
  int            m_iss, m_drp, m_use;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit wants(input logic [1:0] m, input bit v, input bit h, input bit t);
    if (!v) return 1'b0;
    case (m)
      2'd0: return 1'b1;
      2'd1: return !h;
      2'd2: return !h || t;
      default: return 1'b0;
    endcase
  endfunction

  function automatic int sat(input int v);
    return (v > (1 << CW) - 1) ? (1 << CW) - 1 : v;
  endfunction

  task automatic compare_state(input string tag);
    chk(req_valid == (mcount != 0), tag, "req_valid", req_valid, mcount != 0);
    if (mcount != 0) chk(req_line == mq[0], tag, "req_line", req_line, mq[0]);
    chk(cnt_issued == CW'(sat(m_iss)), "R10", "cnt_issued", cnt_issued, sat(m_iss));
    chk(cnt_dropped == CW'(sat(m_drp)), "R7", "cnt_dropped", cnt_dropped, sat(m_drp));
    chk(cnt_useful == CW'(sat(m_use)), "R9", "cnt_useful", cnt_useful, sat(m_use));
  endtask

  task automatic step(input logic [1:0] m, input bit v, input logic [AW-1:0] a,
                      input bit h, input bit t, input bit ph, input bit rdy,
                      input string tag);
    logic [AW-1:0] nxt;
    bit pend, cand, pop, push;
    @(negedge clk);
    compare_state(tag);
    mode = m; acc_valid = v; acc_line = a; acc_hit = h; acc_pf_tag = t;
    probe_hit = ph; req_ready = rdy;
    #1;
    nxt = a + AW'(1);
    chk(probe_line == nxt, "R4", "probe_line", probe_line, nxt);
    chk(clear_tag == (v && h && t), "R9", "clear_tag", clear_tag, v && h && t);
    @(posedge clk);
    pend = 1'b0;
    for (int i = 0; i < mcount; i++) if (mq[i] == nxt) pend = 1'b1;
    cand = wants(m, v, h, t) && !(&a) && !ph && !pend;
    pop  = (mcount != 0) && rdy;
    push = cand && (mcount < QD);
    if (cand && mcount == QD) m_drp++;
    if (pop) m_iss++;
    if (v && h && t) m_use++;
    if (pop) begin
      for (int i = 0; i < QD - 1; i++) mq[i] = mq[i+1];
      mcount--;
    end
    if (push) begin
      mq[mcount] = nxt;
      mcount++;
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 3; i++) step(2'd3, 1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b1, "R8");
  endtask

  initial begin
    void'($urandom(32'd20240517));
    rst_n = 1'b0; mode = 2'd0; acc_valid = 1'b0; acc_line = '0; acc_hit = 1'b0;
    acc_pf_tag = 1'b0; probe_hit = 1'b0; req_ready = 1'b0;
    mcount = 0; m_iss = 0; m_drp = 0; m_use = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    compare_state("R11");

    // R1: hit triggers in mode 0
    step(2'd0, 1'b1, 6'd5, 1'b1, 1'b0, 1'b0, 1'b0, "R1");
    step(2'd3, 1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0, "R1");
    drain();
    // R2: hit ignored, miss triggers in mode 1
    step(2'd1, 1'b1, 6'd9, 1'b1, 1'b0, 1'b0, 1'b0, "R2");
    step(2'd1, 1'b1, 6'd20, 1'b0, 1'b0, 1'b0, 1'b0, "R2");
    step(2'd3, 1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0, "R2");
    drain();
    // R3: untagged hit ignored, tagged hit triggers
    step(2'd2, 1'b1, 6'd30, 1'b1, 1'b0, 1'b0, 1'b0, "R3");
    step(2'd2, 1'b1, 6'd31, 1'b1, 1'b1, 1'b0, 1'b0, "R3");
    step(2'd2, 1'b1, 6'd40, 1'b0, 1'b0, 1'b0, 1'b0, "R3");
    step(2'd3, 1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0, "R3");
    drain();
    // R4: top line suppressed
    step(2'd0, 1'b1, 6'h3f, 1'b0, 1'b0, 1'b0, 1'b0, "R4");
    step(2'd3, 1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0, "R4");
    // R5: already present
    step(2'd0, 1'b1, 6'd12, 1'b0, 1'b0, 1'b1, 1'b0, "R5");
    step(2'd3, 1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0, "R5");
    // R6: duplicate pending
    step(2'd0, 1'b1, 6'd14, 1'b0, 1'b0, 1'b0, 1'b0, "R6");
    step(2'd0, 1'b1, 6'd14, 1'b1, 1'b0, 1'b0, 1'b0, "R6");
    step(2'd3, 1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0, "R6");
    // R7: fill then drop
    step(2'd0, 1'b1, 6'd50, 1'b0, 1'b0, 1'b0, 1'b0, "R7");
    step(2'd0, 1'b1, 6'd52, 1'b0, 1'b0, 1'b0, 1'b1, "R7");
    step(2'd3, 1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0, "R7");
    drain();
    // R11: mode 3 is off
    step(2'd3, 1'b1, 6'd3, 1'b0, 1'b0, 1'b0, 1'b0, "R11");
    step(2'd3, 1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0, "R11");

    // Random traffic, biased to the top of the space; counters saturate (R10)
    for (int n = 0; n < 4000; n++) begin
      logic [AW-1:0] a;
      a = ($urandom_range(0, 3) == 0) ? AW'($urandom_range(60, 63))
                                       : AW'($urandom_range(0, 63));
      step(2'($urandom_range(0, 3)), ($urandom_range(0, 3) != 0), a,
           $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
           $urandom_range(0, 4) == 0, $urandom_range(0, 2) == 0, "R8");
    end
    @(negedge clk);
    compare_state("R10");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule